// File: doc/BRIEF.md
# Tag-Tracked Serial Frame Transmitter

This block turns bytes written by a processor into asynchronous serial characters on a single line. It runs from a master clock that is sixteen times the bit rate. A free-running divider inside the block produces one enable pulse every sixteen master cycles, and every change on the serial line happens on one of those pulses.

A byte is presented on a parallel bus and captured by the rising edge of a write strobe into a one-entry hold register. At the next bit boundary where the output shifter is free, the byte moves into the shifter and the start bit goes out. The ready flag rises at that same moment, so the processor can queue the following byte while the current one is still being sent.

The shifter does not count bits. Two marker bits ride above the data and zeros fill in from the top as it shifts. The position of the markers tells the logic whether the next bit is data, parity or stop, and an all-zero register means the line is idle. Even or odd parity is chosen by a static input.

Top module: `serial_frame_tx`

## Requirements
- R1: The serial output changes only at bit boundaries. Boundaries fall on the 16th master clock edge after reset is released and on every 16th edge after that.
- R2: While reset is held and whenever no character is being sent, `tx` is 1. Out of reset, `tx_ready` is 1.
- R3: A character is a 0 start bit, then the eight data bits with bit 0 first, then one parity bit, then a 1 stop bit. Each bit lasts 16 master cycles.
- R4: With `odd_parity` = 0, the parity bit is the XOR of the eight data bits (even parity). With `odd_parity` = 1, it is the inverse of that XOR (odd parity). The input is taken when the start bit begins.
- R5: `wr_data` is captured only on a 0-to-1 change of `wr_strobe`. Holding the strobe high for many cycles sends exactly one character.
- R6: `tx_ready` goes to 0 on the master edge after a capture. It returns to 1 only on the edge where the hold register moves into the shifter, and that is the same edge where `tx` drops for the start bit.
- R7: A held byte moves into the shifter only when the shifter is idle. A byte written during a character starts exactly one bit after that character's stop bit begins, so start edges are 176 master cycles apart.
- R8: A write while the hold register is full replaces the held byte. `tx_ready` stays 0, and the replaced byte is never sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, 16 times the bit rate |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_strobe | input | 1 | Write strobe; its rising edge captures `wr_data` |
| wr_data | input | 8 | Byte to send |
| odd_parity | input | 1 | 1 selects odd parity, 0 selects even parity |
| tx | output | 1 | Serial output; idles high |
| tx_ready | output | 1 | 1 when the hold register can take a new byte |

## Verification
If the marker bits are misplaced or the zero fill is wrong, the character comes out with the wrong length or with a data bit where the parity or stop bit belongs. This shows at `tx` within the character, at most 176 master cycles after the start edge. A wrong parity accumulator shows only in the parity bit, which is 144 cycles after the start edge, so both parity senses are run over patterns of different weight. A wrong hold-register flag shows at `tx_ready` on the next master edge after a write, or as a lost, repeated or stale character at the following bit boundary.

// File: rtl/serial_tx_pkg.sv
// Package: shared constants and types for the serial frame transmitter.
// Assumes: two marker bits sit above the data in the shifter.
package serial_tx_pkg;

    // Number of marker bits appended above the data in the shifter
    localparam int unsigned MARK_BITS = 2;

    // Phase of the character, decoded from where the markers sit
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_DATA   = 2'd1,
        PH_PARITY = 2'd2,
        PH_STOP   = 2'd3
    } tx_phase_e;

endpackage

// File: rtl/tx_baud_div.sv
// Module: tx_baud_div
// Divides the master clock into a one-cycle bit enable.
// Assumes: RATIO >= 2. The counter runs freely from reset, and the enable
// is high in the cycle where the counter holds its terminal value.
module tx_baud_div #(
    parameter int unsigned RATIO = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic baud_tick
);
    localparam int unsigned CNT_W = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RATIO - 1);

    logic [CNT_W-1:0] cnt;

    // Purpose: free-running count with wrap at the terminal value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Purpose: enable for exactly one master cycle per bit
    always_comb begin
        baud_tick = (cnt == LAST);
    end

endmodule

// File: rtl/tx_hold_reg.sv
// Module: tx_hold_reg
// One-entry hold register written on a rising strobe edge.
// Assumes: the strobe is synchronous to clk. A write while full overwrites
// the held byte. When a write and a transfer fall in the same cycle, the old
// byte is transferred and the new byte stays held.
module tx_hold_reg #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_strobe,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_full,
    output logic              wr_edge
);
    logic strobe_q;

    // Purpose: remember the last strobe level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= wr_strobe;
        end
    end

    // Purpose: a write is a low-to-high change of the strobe
    always_comb begin
        wr_edge = wr_strobe & ~strobe_q;
    end

    // Purpose: capture the byte and track whether the register is occupied
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_data <= '0;
            hold_full <= 1'b0;
        end else begin
            if (wr_edge) begin
                hold_data <= wr_data;
            end
            if (wr_edge) begin
                hold_full <= 1'b1;
            end else if (take) begin
                hold_full <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tx_tag_shifter.sv
// Module: tx_tag_shifter
// Output shifter that tracks the character by marker bits rather than a
// counter. On load it holds {markers, data}. Each bit step shifts right with
// zero fill. The character phase is decoded from the remaining pattern.
// Assumes: baud_tick is one master cycle wide and odd_parity is static
// during a character.
module tx_tag_shifter
    import serial_tx_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              odd_parity,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              hold_full,
    output logic              take,
    output logic              done,
    output logic              tx
);
    localparam int unsigned SR_W = DATA_W + MARK_BITS;

    logic [SR_W-1:0] sr;
    logic            par_acc;
    tx_phase_e       phase;

    // Purpose: decode the phase from marker position and zero fill
    always_comb begin
        if (sr == '0) begin
            phase = PH_IDLE;
        end else if (sr[SR_W-1:MARK_BITS] != '0) begin
            phase = PH_DATA;
        end else if (sr[1]) begin
            phase = PH_PARITY;
        end else begin
            phase = PH_STOP;
        end
    end

    // Purpose: shifter is idle once every bit including the stop has gone out
    always_comb begin
        done = (phase == PH_IDLE);
    end

    // Purpose: move the held byte in at a bit boundary while idle
    always_comb begin
        take = baud_tick & done & hold_full;
    end

    // Purpose: load, shift, accumulate parity and drive the line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr      <= '0;
            par_acc <= 1'b0;
            tx      <= 1'b1;
        end else if (take) begin
            sr      <= {{MARK_BITS{1'b1}}, hold_data};
            par_acc <= odd_parity;
            tx      <= 1'b0;
        end else if (baud_tick && !done) begin
            sr <= {1'b0, sr[SR_W-1:1]};
            unique case (phase)
                PH_DATA: begin
                    tx      <= sr[0];
                    par_acc <= par_acc ^ sr[0];
                end
                PH_PARITY: begin
                    tx <= par_acc;
                end
                PH_STOP: begin
                    tx <= 1'b1;
                end
                default: begin
                    tx <= 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/serial_frame_tx.sv
// Module: serial_frame_tx
// Top of the serial transmitter: bit-rate divider, one-entry hold register
// and marker-tracked output shifter.
// Assumes: a single master clock at OVERSAMPLE times the bit rate; all inputs
// synchronous to it.
module serial_frame_tx #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_strobe,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              odd_parity,
    output logic              tx,
    output logic              tx_ready
);
    logic              baud_tick;
    logic              take;
    logic              done;
    logic              hold_full;
    logic              wr_edge;
    logic [DATA_W-1:0] hold_data;

    tx_baud_div #(
        .RATIO(OVERSAMPLE)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .baud_tick(baud_tick)
    );

    tx_hold_reg #(
        .DATA_W(DATA_W)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_strobe(wr_strobe),
        .wr_data  (wr_data),
        .take     (take),
        .hold_data(hold_data),
        .hold_full(hold_full),
        .wr_edge  (wr_edge)
    );

    tx_tag_shifter #(
        .DATA_W(DATA_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .odd_parity(odd_parity),
        .hold_data (hold_data),
        .hold_full (hold_full),
        .take      (take),
        .done      (done),
        .tx        (tx)
    );

    // Purpose: ready whenever the hold register is empty
    always_comb begin
        tx_ready = ~hold_full;
    end

endmodule

// File: rtl/serial_frame_tx_checker.sv
// Module: serial_frame_tx_checker
// Temporal checks on the transmitter, bound to serial_frame_tx.
// Assumes: it sees the divider enable, the load strobe and the idle flag of
// the top-level instance.
module serial_frame_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic tx,
    input logic tx_ready,
    input logic baud_tick,
    input logic wr_edge,
    input logic take,
    input logic done
);
    logic [4:0] gap_ticks;
    logic       seen_take;

    // Purpose: count bit boundaries since the last load (saturating)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_ticks <= '0;
            seen_take <= 1'b0;
        end else if (take) begin
            gap_ticks <= '0;
            seen_take <= 1'b1;
        end else if (baud_tick && gap_ticks != 5'd31) begin
            gap_ticks <= gap_ticks + 5'd1;
        end
    end

    assert_tx_on_boundary_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(baud_tick) |-> $stable(tx));

    assert_idle_line_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> tx);

    assert_start_after_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !tx);

    assert_ready_rise_with_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready) |-> (!tx && $past(take)));

    assert_write_clears_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_edge |=> !tx_ready);

    assert_full_frame_between_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && seen_take) |-> (gap_ticks >= 5'd10));

endmodule

bind serial_frame_tx serial_frame_tx_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx       (tx),
    .tx_ready (tx_ready),
    .baud_tick(baud_tick),
    .wr_edge  (wr_edge),
    .take     (take),
    .done     (done)
);

// File: tb/test_serial_frame_tx.sv
// Bench: scoreboard for serial_frame_tx. The driver queues expected
// characters; a line monitor decodes tx and compares against the queue.
module test_serial_frame_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_strobe = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       odd_parity = 1'b0;
    logic       tx;
    logic       tx_ready;

    always #4 clk = ~clk;

    serial_frame_tx i_serial_frame_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_strobe (wr_strobe),
        .wr_data   (wr_data),
        .odd_parity(odd_parity),
        .tx        (tx),
        .tx_ready  (tx_ready)
    );

    typedef struct packed {
        logic [7:0] d;
        logic       p;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   ended = 1'b0;
    int   cyc = 0;
    bit   mon_busy = 1'b0;
    int   mon_frames = 0;
    int   last_gap = 0;
    logic [7:0] last_rx = 8'h00;

    // Purpose: master edges counted from reset release
    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Purpose: write one byte, holding the strobe high for hold_cycles
    task automatic send(input logic [7:0] d, input int hold_cycles);
        exp_t e;
        bit   repl;
        @(negedge clk);
        repl = !tx_ready;
        e.d = d;
        e.p = (^d) ^ odd_parity;
        if (repl && q.size() > 0) q[q.size()-1] = e;
        else q.push_back(e);
        wr_data   = d;
        wr_strobe = 1'b1;
        @(negedge clk);
        chk(!tx_ready, "R6 ready low after write", tx_ready, 0);
        repeat (hold_cycles - 1) @(negedge clk);
        wr_strobe = 1'b0;
    endtask

    task automatic wait_ready();
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
    endtask

    task automatic drain();
        @(negedge clk);
        while (q.size() != 0 || mon_busy) @(negedge clk);
        repeat (40) @(negedge clk);
    endtask

    // Purpose: decode characters on tx and compare with the queue
    initial begin
        logic prev_tx;
        int   start_cyc;
        int   last_start;
        bit   have_last;
        logic [7:0] d;
        logic p;
        logic s;
        exp_t e;
        prev_tx   = 1'b1;
        have_last = 1'b0;
        last_start = 0;
        forever begin
            @(negedge clk);
            if (rst_n && prev_tx === 1'b1 && tx === 1'b0) begin
                mon_busy  = 1'b1;
                start_cyc = cyc;
                chk((start_cyc % 16) == 0, "R1 start on boundary", start_cyc % 16, 0);
                if (have_last) begin
                    last_gap = start_cyc - last_start;
                    chk(last_gap >= 176, "R7 spacing", last_gap, 176);
                end
                last_start = start_cyc;
                have_last  = 1'b1;
                repeat (8) @(negedge clk);
                chk(tx === 1'b0, "R3 start bit", tx, 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (16) @(negedge clk);
                    d[i] = tx;
                end
                repeat (16) @(negedge clk);
                p = tx;
                repeat (16) @(negedge clk);
                s = tx;
                chk(s === 1'b1, "R3 stop bit", s, 1);
                if (q.size() == 0) begin
                    chk(1'b0, "R5 R8 unexpected character", d, 0);
                end else begin
                    e = q.pop_front();
                    chk(d === e.d, "R3 data", d, e.d);
                    chk(p === e.p, "R4 parity", p, e.p);
                end
                last_rx = d;
                mon_frames++;
                mon_busy = 1'b0;
            end
            prev_tx = tx;
        end
    end

    // Purpose: watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    // Purpose: stimulus sequence
    initial begin
        int f0;
        repeat (5) @(negedge clk);
        chk(tx === 1'b1, "R2 tx in reset", tx, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_ready === 1'b1, "R2 ready after reset", tx_ready, 1);
        repeat (40) @(negedge clk);
        chk(tx === 1'b1, "R2 idle line", tx, 1);

        // Patterns under even parity (R3, R4)
        odd_parity = 1'b0;
        send(8'h55, 1); drain();
        send(8'hA3, 1); drain();
        send(8'h01, 1); drain();
        // Patterns under odd parity (R4)
        odd_parity = 1'b1;
        send(8'h00, 1); drain();
        send(8'hFF, 1); drain();
        send(8'h80, 1); drain();
        send(8'h6E, 1); drain();
        odd_parity = 1'b0;

        // R6: ready rises together with the start bit
        send(8'h96, 1);
        wait_ready();
        chk(tx === 1'b0, "R6 ready with start", tx, 0);
        drain();

        // R7: back-to-back characters
        send(8'h3C, 1);
        wait_ready();
        send(8'hC3, 1);
        drain();
        chk(last_gap == 176, "R7 back-to-back spacing", last_gap, 176);

        // R8: overwrite while full
        f0 = mon_frames;
        send(8'h11, 1);
        wait_ready();
        send(8'h22, 1);
        repeat (20) @(negedge clk);
        send(8'h33, 1);
        repeat (30) @(negedge clk);
        chk(!tx_ready, "R8 ready stays low", tx_ready, 0);
        drain();
        chk(mon_frames == f0 + 2, "R8 character count", mon_frames - f0, 2);
        chk(last_rx == 8'h33, "R8 replacing byte sent", last_rx, 8'h33);

        // R5: long strobe sends one character
        f0 = mon_frames;
        send(8'h5A, 60);
        drain();
        repeat (200) @(negedge clk);
        chk(mon_frames == f0 + 1, "R5 one per rising edge", mon_frames - f0, 1);

        // Sweep of more patterns, alternating parity sense
        for (int k = 0; k < 8; k++) begin
            odd_parity = k[0];
            send(8'(k * 37 + 9), 1);
            drain();
        end

        chk(q.size() == 0, "R8 no pending characters", q.size(), 0);
        chk(tx === 1'b1, "R2 idle at end", tx, 1);
        finish_run();
    end

endmodule